// File: doc/BRIEF.md
# Bass lockout controller

This block supervises a bass level controller using a stream of pass/fail verdicts from a spectrum checker. Each cycle can carry one verdict, or none. The first fail locks the bass setting. A second fail while the block is still failing cuts the bass. The lock is released only after a run of consecutive passes has drained a small hold counter. Commands leave the block as one-cycle pulses, each with a 2-bit code.

There are three named states: PASSED (the reset state), FAILED and LOCKED. There are six named transitions:
- lock_on_fail: PASSED to FAILED.
- cut_on_refail: FAILED to FAILED.
- settle_on_pass: FAILED to LOCKED.
- relapse_on_fail: LOCKED to FAILED.
- drain_on_pass: LOCKED to LOCKED.
- release_on_drain: LOCKED to PASSED.

Holding in PASSED on a pass, and every cycle without a verdict, are idle self-loops. The hold counter is 2 bits wide and is reloaded with the limit `HOLD_LIM` (default 3) on every fail. A pass in LOCKED decrements it, and the decrement stops at zero.

Top module: `bass_lockout_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `cmd_vld` is 0. The block starts in PASSED with the hold counter at 0, so the first fail verdict after reset yields a Lock command.
- R2: In PASSED, a pass verdict emits no command and leaves the state in PASSED.
- R3: In PASSED, a fail verdict (lock_on_fail) emits the Lock command (code 0), loads the counter with `HOLD_LIM` and moves to FAILED.
- R4: In FAILED, a fail verdict (cut_on_refail) emits the CutBass command (code 2), reloads the counter with `HOLD_LIM` and stays in FAILED.
- R5: In FAILED, a pass verdict (settle_on_pass) moves to LOCKED and emits no command. The counter is not changed.
- R6: In LOCKED, a fail verdict (relapse_on_fail) reloads the counter with `HOLD_LIM`, returns to FAILED and emits no command.
- R7: In LOCKED, a pass verdict decrements the counter, which never goes below 0. If the decremented value is 0 (release_on_drain), the block emits the Release command (code 1) and returns to PASSED. Otherwise (drain_on_pass) it stays in LOCKED with no command. With the default limit, Release comes on the third consecutive pass in LOCKED.
- R8: A cycle with `vrd_vld` low leaves the state and the counter unchanged and emits no command.
- R9: A command is registered. `cmd_vld` is high for exactly the one cycle after the clock edge that sampled the verdict, and `cmd_code` is valid in that cycle. Code 3 is never emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vrd_vld | input | 1 | A verdict is present this cycle |
| vrd_fail | input | 1 | Verdict value: 1 = fail, 0 = pass (used only with vrd_vld) |
| cmd_vld | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Command: 0 Lock, 1 Release, 2 CutBass |

## Verification
The main function is exercised with every sequence of seven symbols drawn from {no verdict, pass, fail}. This covers every transition from every state and every counter value. It also shows apart a release after three passes from one after two or four passes, and a counter that was reloaded from one that was not.

Each sequence starts right after a reset applied on top of whatever state the previous sequence left. This shows that reset always returns the block to PASSED.

Gaps with no verdict are mixed into the sequences. Because of this, a counter that moves or a command that fires on an absent cycle would shift the timing of a later Release and be caught.

// File: rtl/bass_lockout_pkg.sv
package bass_lockout_pkg;

    typedef enum logic [1:0] {
        ST_PASSED = 2'd0,
        ST_FAILED = 2'd1,
        ST_LOCKED = 2'd2
    } lk_state_e;

    typedef enum logic [1:0] {
        CMD_LOCK    = 2'd0,
        CMD_RELEASE = 2'd1,
        CMD_CUT     = 2'd2
    } lk_cmd_e;

    localparam int CMD_W = 2;

endpackage

// File: rtl/bass_lockout_hold_cnt.sv
// Hold counter: reload on fail, saturating decrement on pass in LOCKED.
module bass_lockout_hold_cnt #(
    parameter int CNT_W    = 2,
    parameter int HOLD_LIM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             dec_hits_zero
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(HOLD_LIM);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;

    // The decrement stops at zero instead of wrapping.
    always_comb begin
        if (cnt_q == '0) begin
            cnt_dec = '0;
        end else begin
            cnt_dec = cnt_q - ONE_V;
        end
    end

    assign dec_hits_zero = (cnt_dec == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LIM_V;
        end else if (dec) begin
            cnt_q <= cnt_dec;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bass_lockout_cmd_reg.sv
// Registered command pulse and code.
module bass_lockout_cmd_reg #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [CODE_W-1:0] code_d,
    output logic              vld,
    output logic [CODE_W-1:0] code
);
    logic              vld_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            code_q <= '0;
        end else begin
            vld_q <= fire;
            if (fire) begin
                code_q <= code_d;
            end
        end
    end

    assign vld  = vld_q;
    assign code = code_q;
endmodule

// File: rtl/bass_lockout_ctrl.sv
// Verdict-driven lockout controller: PASSED / FAILED / LOCKED with hold counter.
module bass_lockout_ctrl
    import bass_lockout_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int HOLD_LIM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vrd_vld,
    input  logic             vrd_fail,
    output logic             cmd_vld,
    output logic [CMD_W-1:0] cmd_code
);
    lk_state_e        state_q;
    lk_state_e        state_d;
    logic             cnt_load;
    logic             cnt_dec;
    logic             dec_hits_zero;
    logic [CNT_W-1:0] cnt_q;
    logic             cmd_fire;
    lk_cmd_e          cmd_sel;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASSED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and command selection
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cmd_fire = 1'b0;
        cmd_sel  = CMD_LOCK;
        if (vrd_vld) begin
            unique case (state_q)
                ST_PASSED: begin
                    if (vrd_fail) begin          // lock_on_fail
                        cmd_fire = 1'b1;
                        cmd_sel  = CMD_LOCK;
                        cnt_load = 1'b1;
                        state_d  = ST_FAILED;
                    end
                end
                ST_FAILED: begin
                    if (vrd_fail) begin          // cut_on_refail
                        cmd_fire = 1'b1;
                        cmd_sel  = CMD_CUT;
                        cnt_load = 1'b1;
                    end else begin               // settle_on_pass
                        state_d = ST_LOCKED;
                    end
                end
                ST_LOCKED: begin
                    if (vrd_fail) begin          // relapse_on_fail
                        cnt_load = 1'b1;
                        state_d  = ST_FAILED;
                    end else begin
                        cnt_dec = 1'b1;
                        if (dec_hits_zero) begin // release_on_drain
                            cmd_fire = 1'b1;
                            cmd_sel  = CMD_RELEASE;
                            state_d  = ST_PASSED;
                        end                      // else drain_on_pass
                    end
                end
                default: begin
                    state_d = ST_PASSED;
                end
            endcase
        end
    end

    bass_lockout_hold_cnt #(
        .CNT_W    (CNT_W),
        .HOLD_LIM (HOLD_LIM)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (cnt_load),
        .dec           (cnt_dec),
        .cnt           (cnt_q),
        .dec_hits_zero (dec_hits_zero)
    );

    bass_lockout_cmd_reg #(
        .CODE_W (CMD_W)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (cmd_fire),
        .code_d (cmd_sel),
        .vld    (cmd_vld),
        .code   (cmd_code)
    );
endmodule

// File: rtl/bass_lockout_chk.sv
module bass_lockout_chk
    import bass_lockout_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int HOLD_LIM = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vrd_vld,
    input logic             vrd_fail,
    input logic             cmd_vld,
    input logic [CMD_W-1:0] cmd_code,
    input lk_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(HOLD_LIM);

    // R2
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASSED && vrd_vld && !vrd_fail) |=> (!cmd_vld && state_q == ST_PASSED));

    // R3
    lock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASSED && vrd_vld && vrd_fail) |=>
            (cmd_vld && cmd_code == CMD_LOCK && state_q == ST_FAILED && cnt_q == LIM_V));

    // R4
    cut_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && vrd_vld && vrd_fail) |=>
            (cmd_vld && cmd_code == CMD_CUT && cnt_q == LIM_V));

    // R5
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && vrd_vld && !vrd_fail) |=> (!cmd_vld && state_q == ST_LOCKED));

    // R6
    relapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && vrd_vld && vrd_fail) |=>
            (!cmd_vld && state_q == ST_FAILED && cnt_q == LIM_V));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code == CMD_RELEASE) |-> (state_q == ST_PASSED && cnt_q == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vrd_vld |=> (!cmd_vld && $stable(state_q) && $stable(cnt_q)));

    // R9
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> ($past(vrd_vld) && cmd_code != 2'd3));
endmodule

bind bass_lockout_ctrl bass_lockout_chk #(
    .CNT_W    (CNT_W),
    .HOLD_LIM (HOLD_LIM)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vrd_vld  (vrd_vld),
    .vrd_fail (vrd_fail),
    .cmd_vld  (cmd_vld),
    .cmd_code (cmd_code),
    .state_q  (state_q),
    .cnt_q    (cnt_q)
);

// File: tb/bass_lockout_ctrl_tb.sv
`timescale 1ns/1ps
module bass_lockout_ctrl_tb;
    localparam int LIM     = 3;
    localparam int SEQ_LEN = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vrd_vld = 1'b0;
    logic       vrd_fail = 1'b0;
    logic       cmd_vld;
    logic [1:0] cmd_code;

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 PASSED, 1 FAILED, 2 LOCKED
    int    m_st  = 0;
    int    m_cnt = 0;
    logic  p_vld = 1'b0;
    logic [1:0] p_code = 2'd0;
    string p_tag = "R1";
    logic  pending = 1'b0;

    always #2.5 clk = ~clk;

    bass_lockout_ctrl #(.CNT_W(2), .HOLD_LIM(LIM)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vrd_vld  (vrd_vld),
        .vrd_fail (vrd_fail),
        .cmd_vld  (cmd_vld),
        .cmd_code (cmd_code)
    );

    task automatic check_out(input string tag, input logic ev, input logic [1:0] ec);
        checks++;
        if (cmd_vld !== ev || (ev && cmd_code !== ec)) begin
            errors++;
            $display("FAIL %s: cmd_vld=%b cmd_code=%0d expected vld=%b code=%0d",
                     tag, cmd_vld, cmd_code, ev, ec);
        end
    endtask

    // sym: 0 no verdict, 1 pass, 2 fail
    task automatic model(input int sym);
        p_vld  = 1'b0;
        p_code = 2'd0;
        if (sym == 0) begin
            p_tag = "R8";
        end else begin
            case (m_st)
                0: if (sym == 2) begin
                       p_vld = 1'b1; p_code = 2'd0; m_st = 1; m_cnt = LIM; p_tag = "R3";
                   end else p_tag = "R2";
                1: if (sym == 2) begin
                       p_vld = 1'b1; p_code = 2'd2; m_cnt = LIM; p_tag = "R4";
                   end else begin
                       m_st = 2; p_tag = "R5";
                   end
                default: if (sym == 2) begin
                       m_st = 1; m_cnt = LIM; p_tag = "R6";
                   end else begin
                       if (m_cnt > 0) m_cnt--;
                       if (m_cnt == 0) begin
                           p_vld = 1'b1; p_code = 2'd1; m_st = 0;
                       end
                       p_tag = "R7";
                   end
            endcase
        end
    endtask

    task automatic step(input int sym);
        @(negedge clk);
        if (pending) check_out(p_tag, p_vld, p_code);
        vrd_vld  = (sym != 0);
        vrd_fail = (sym == 2);
        model(sym);
        pending = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pending) check_out(p_tag, p_vld, p_code);
        vrd_vld  = 1'b0;
        vrd_fail = 1'b0;
        pending  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vrd_vld = 1'b0; vrd_fail = 1'b0;
        @(negedge clk);
        check_out("R1", 1'b0, 2'd0);
        @(negedge clk);
        check_out("R1", 1'b0, 2'd0);
        rst_n = 1'b1;
        m_st = 0; m_cnt = 0; pending = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R9: directed pulse timing: fail, then gap; pulse exactly one cycle
        step(2); step(0); step(0); flush();
        // R7: release on third pass in LOCKED, with gaps between passes
        do_reset();
        step(2); step(1); step(1); step(0); step(1); step(0); step(1); flush();
        // R6: relapse reloads the counter
        do_reset();
        step(2); step(1); step(1); step(1); step(2); step(1); step(1); step(1); step(1); flush();

        // Exhaustive sweep over all 3^SEQ_LEN symbol sequences
        for (int n = 0; n < 2187; n++) begin
            int v;
            do_reset();
            v = n;
            for (int k = 0; k < SEQ_LEN; k++) begin
                step(v % 3);
                v = v / 3;
            end
            flush();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule